// File: doc/BRIEF.md
# Oversampling Majority-Vote Serial Receiver

This block recovers asynchronous serial characters from a single idle-high line. A separate enable pulse, `sample_tick`, arrives sixteen times per bit period. The receiver passes the line through a two-flop synchroniser. It starts a frame on a falling edge seen between two ticks. Each bit is then decided by a majority of three samples taken around the middle of the bit slot. An eight-bit character with no parity is assembled from these bits.

A frame has ten slots: one start bit, eight data bits with the least significant bit first, and one stop bit. The character is delivered as soon as the stop bit has been voted on, halfway through its slot. The receiver goes back to looking for a start edge in that same tick. This gives margin against a sender whose clock runs a few percent fast. A stop bit that votes low is still delivered, with a framing-error flag. A start bit that votes high is treated as noise, and no character is produced.

Top module: `uart_mv_rx`

## Requirements
- R1: The receiver's timing and sampling advance only in clock cycles where `sample_tick` is high. One bit slot is sixteen ticks.
- R2: A frame starts when the synchronised line was high at one tick and is low at the next. The detecting tick counts as sub-slot 0 of slot 0, the start slot. A line that stays high keeps the receiver idle.
- R3: Each slot's value is the majority of the synchronised line at sub-slots 7, 8 and 9. A single disturbed sample does not change the bit, and two disturbed samples do.
- R4: Slots 1 to 8 carry data, least significant bit first. Slot 1 lands in `rx_data[0]` and slot 8 in `rx_data[7]`.
- R5: `rx_valid` is high for exactly one clock cycle, one cycle after the tick at sub-slot 9 of slot 9, the stop slot. `rx_data` keeps the last character until the next strobe.
- R6: In the tick that decides the stop bit, the receiver is already idle and armed. The rest of the stop slot and any further stop time are ignored. Back-to-back frames from a sender with a 63-clock bit, compared with a nominal 64, are all received.
- R7: `rx_frame_err` is high together with `rx_valid` when the stop-bit vote is low. Otherwise it is low. The data byte is delivered in both cases.
- R8: If the start-slot vote reads high, the receiver returns to idle and produces no strobe.
- R9: After reset, `rx_valid` and `rx_frame_err` are 0 and `rx_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_tick | input | 1 | One-cycle enable, sixteen per bit period |
| rxd | input | 1 | Asynchronous serial line, idle high |
| rx_data | output | 8 | Last received character |
| rx_valid | output | 1 | One-cycle strobe when a character is complete |
| rx_frame_err | output | 1 | Stop bit voted low, qualified by `rx_valid` |

## Verification
The bench builds the block with its defaults: sixteen sub-slots, eight data bits and two synchroniser stages. It drives a tick on every fourth clock, so a nominal bit lasts 64 clocks. The sample points fall at clock offsets 28 to 39 into each bit, whatever the tick phase. This lets the bench place a one-clock disturbance that can reach at most one vote sample, and an eight-clock disturbance that always covers two. A sender with a 63-clock bit, sent back to back, reaches the next start edge before the end of the receiver's stop slot. Only early re-arming decodes that stream.

// File: rtl/uart_mv_rx_pkg.sv
// Shared types and helpers for the majority-vote serial receiver.
// Assumes: nothing beyond standard SystemVerilog.
package uart_mv_rx_pkg;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_BUSY = 1'b1
    } rx_state_e;

    // Two-of-three majority.
    function automatic logic majority3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_mv_rx_sync.sv
// Multi-flop synchroniser for the asynchronous serial line.
// Assumes STAGES >= 2. Resets to the idle (high) level.
module uart_mv_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    // Shift the raw line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/uart_mv_rx_vote.sv
// Captures the line at the first two vote sub-slots of a bit slot, and votes them
// with the live line at the third sub-slot.
// Assumes the vote is read only at sub-slot FIRST_SUB+2 on a tick.
module uart_mv_rx_vote #(
    parameter int SUB_W     = 4,
    parameter int FIRST_SUB = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             line,
    input  logic [SUB_W-1:0] sub,
    output logic             vote
);
    import uart_mv_rx_pkg::*;

    logic [1:0] samp;

    for (genvar g = 0; g < 2; g++) begin : g_cap
        // Hold the line value seen at vote sub-slot FIRST_SUB+g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                samp[g] <= 1'b1;
            else if (tick && sub == SUB_W'(FIRST_SUB + g))
                samp[g] <= line;
        end
    end

    assign vote = majority3(samp[0], samp[1], line);

    // R1: captured samples only move on tick cycles.
    a_r1_samples_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(samp));

endmodule

// File: rtl/uart_mv_rx_ctrl.sv
// Frame timing for the receiver. It tracks sub-slot and slot counters, detects the
// start edge, aborts on a noisy start bit, and re-arms right after the stop decision.
// Assumes the line is already synchronised and the tick is a one-cycle pulse.
module uart_mv_rx_ctrl #(
    parameter int OSR       = 16,
    parameter int DATA_BITS = 8,
    parameter int SUB_W     = $clog2(OSR),
    parameter int SLOT_W    = $clog2(DATA_BITS + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic              vote,
    output logic [SUB_W-1:0]  sub,
    output logic [SLOT_W-1:0] slot,
    output logic              decide
);
    import uart_mv_rx_pkg::*;

    localparam int DECIDE_SUB = OSR / 2 + 1;
    localparam int STOP_SLOT  = DATA_BITS + 1;

    rx_state_e state;
    logic      prev_line;

    assign decide = tick && (state == RX_BUSY) && (sub == SUB_W'(DECIDE_SUB));

    // Remember the line at each tick, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)    prev_line <= 1'b1;
        else if (tick) prev_line <= line;
    end

    // Sequence the idle/busy state and the sub-slot and slot counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            sub   <= '0;
            slot  <= '0;
        end else if (tick) begin
            unique case (state)
                RX_IDLE: begin
                    if (prev_line && !line) begin
                        state <= RX_BUSY;
                        sub   <= SUB_W'(1);
                        slot  <= '0;
                    end
                end
                RX_BUSY: begin
                    if (sub == SUB_W'(DECIDE_SUB) &&
                        (slot == SLOT_W'(STOP_SLOT) || (slot == '0 && vote))) begin
                        state <= RX_IDLE;
                        sub   <= '0;
                        slot  <= '0;
                    end else if (sub == SUB_W'(OSR - 1)) begin
                        sub  <= '0;
                        slot <= slot + SLOT_W'(1);
                    end else begin
                        sub <= sub + SUB_W'(1);
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // R2: an idle receiver seeing a high line at a tick stays idle.
    a_r2_high_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE && tick && line) |=> state == RX_IDLE);

    // R6: the stop decision leaves the receiver armed in the next cycle.
    a_r6_rearm_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && slot == SLOT_W'(STOP_SLOT)) |=> state == RX_IDLE);

    // R8: a start bit voted high aborts the frame.
    a_r8_glitch_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && slot == '0 && vote) |=> state == RX_IDLE);

endmodule

// File: rtl/uart_mv_rx.sv
// Top of the majority-vote serial receiver: 1 start, DATA_BITS data (LSB first),
// no parity, 1 stop. It reports each character at the middle of the stop slot.
// Assumes sample_tick is a one-cycle pulse at OSR times the bit rate.
module uart_mv_rx #(
    parameter int OSR         = 16,
    parameter int DATA_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_tick,
    input  logic                 rxd,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 rx_frame_err
);

    localparam int SUB_W     = $clog2(OSR);
    localparam int SLOT_W    = $clog2(DATA_BITS + 2);
    localparam int STOP_SLOT = DATA_BITS + 1;
    localparam int FIRST_SUB = OSR / 2 - 1;

    logic                 line;
    logic                 vote;
    logic                 decide;
    logic [SUB_W-1:0]     sub;
    logic [SLOT_W-1:0]    slot;
    logic [DATA_BITS-1:0] shreg;

    uart_mv_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (line)
    );

    uart_mv_rx_vote #(.SUB_W(SUB_W), .FIRST_SUB(FIRST_SUB)) u_vote (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (sample_tick),
        .line (line),
        .sub  (sub),
        .vote (vote)
    );

    uart_mv_rx_ctrl #(.OSR(OSR), .DATA_BITS(DATA_BITS), .SUB_W(SUB_W), .SLOT_W(SLOT_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (sample_tick),
        .line  (line),
        .vote  (vote),
        .sub   (sub),
        .slot  (slot),
        .decide(decide)
    );

    // Shift each voted data bit in from the top, so the first bit ends at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '0;
        else if (decide && slot != '0 && slot != SLOT_W'(STOP_SLOT))
            shreg <= {vote, shreg[DATA_BITS-1:1]};
    end

    // Publish the character, strobe and framing flag at the stop decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data      <= '0;
            rx_valid     <= 1'b0;
            rx_frame_err <= 1'b0;
        end else if (decide && slot == SLOT_W'(STOP_SLOT)) begin
            rx_data      <= shreg;
            rx_valid     <= 1'b1;
            rx_frame_err <= !vote;
        end else begin
            rx_valid     <= 1'b0;
            rx_frame_err <= 1'b0;
        end
    end

    // R5: the strobe lasts a single cycle.
    a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R5: the data output only changes along with a strobe.
    a_r5_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> (rx_valid || $stable(rx_data)));

    // R7: the framing flag never appears without the strobe.
    a_r7_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_err |-> rx_valid);

endmodule

// File: tb/uart_mv_rx_test.sv
// Self-checking bench for uart_mv_rx: a vector table of frames, then directed tests.
module uart_mv_rx_test;

    localparam int NBIT = 64;
    localparam int NVEC = 8;
    // Each entry is {stop bit level, data byte}.
    localparam logic [8:0] VECS [NVEC] = '{
        9'h155, 9'h1A3, 9'h100, 9'h1FF, 9'h101, 9'h180, 9'h03C, 9'h000
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick;
    logic       rxd = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_frame_err;
    logic [1:0] tdiv;

    int   vectors = 0;
    int   fails = 0;
    int   got_cnt = 0;
    logic [7:0] hist_d [16];
    logic       hist_e [16];

    uart_mv_rx uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_tick (sample_tick),
        .rxd         (rxd),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid),
        .rx_frame_err(rx_frame_err)
    );

    always #4 clk = ~clk;

    // Tick on every fourth clock.
    always_ff @(posedge clk) begin
        if (!rst_n) tdiv <= 2'd0;
        else        tdiv <= tdiv + 2'd1;
    end
    assign sample_tick = (tdiv == 2'd3);

    // Record each strobe, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            hist_d[got_cnt[3:0]] = rx_data;
            hist_e[got_cnt[3:0]] = rx_frame_err;
            got_cnt = got_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Send one frame. Optionally invert the line in slot gslot for clocks [gfrom, gto).
    task automatic send(input logic [7:0] d, input logic stop, input int cpb,
                        input int gslot, input int gfrom, input int gto);
        logic [9:0] bits;
        bits = {stop, d, 1'b0};
        for (int s = 0; s < 10; s++) begin
            for (int c = 0; c < cpb; c++) begin
                rxd = (s == gslot && c >= gfrom && c < gto) ? ~bits[s] : bits[s];
                @(negedge clk);
            end
        end
    endtask

    task automatic idle(input int n);
        rxd = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int n0;
        repeat (4) @(negedge clk);
        // R9: reset state
        check(rx_valid == 1'b0, "R9 valid", rx_valid, 0);
        check(rx_frame_err == 1'b0, "R9 err", rx_frame_err, 0);
        check(rx_data == 8'h00, "R9 data", rx_data, 0);
        rst_n = 1'b1;
        idle(2 * NBIT);
        check(got_cnt == 0, "R2 idle no strobe", got_cnt, 0);

        // Table walk: R4 data order, R7 framing flag, R5 single strobe.
        for (int v = 0; v < NVEC; v++) begin
            n0 = got_cnt;
            send(VECS[v][7:0], VECS[v][8], NBIT, -1, 0, 0);
            idle(NBIT);
            check(got_cnt == n0 + 1, "R5 one strobe", got_cnt - n0, 1);
            check(hist_d[n0[3:0]] == VECS[v][7:0], "R4 data", hist_d[n0[3:0]], VECS[v][7:0]);
            check(hist_e[n0[3:0]] == !VECS[v][8], "R7 frame err", hist_e[n0[3:0]], !VECS[v][8]);
        end

        // R3: a one-clock disturbance reaches at most one vote sample.
        n0 = got_cnt;
        send(8'h00, 1'b1, NBIT, 6, 32, 33);
        idle(NBIT);
        check(hist_d[n0[3:0]] == 8'h00, "R3 single sample outvoted", hist_d[n0[3:0]], 8'h00);

        // R3: an eight-clock disturbance always covers two vote samples.
        n0 = got_cnt;
        send(8'h00, 1'b1, NBIT, 4, 28, 36);
        idle(NBIT);
        check(hist_d[n0[3:0]] == 8'h08, "R3 two samples flip", hist_d[n0[3:0]], 8'h08);

        // R8: a short low pulse is rejected at the start vote.
        n0 = got_cnt;
        rxd = 1'b0;
        repeat (16) @(negedge clk);
        idle(12 * NBIT);
        check(got_cnt == n0, "R8 glitch no strobe", got_cnt - n0, 0);
        send(8'h96, 1'b1, NBIT, -1, 0, 0);
        idle(NBIT);
        check(hist_d[n0[3:0]] == 8'h96, "R8 recovers", hist_d[n0[3:0]], 8'h96);

        // R6: back-to-back frames at nominal rate, then from a fast sender.
        n0 = got_cnt;
        send(8'h5A, 1'b1, NBIT, -1, 0, 0);
        send(8'hC3, 1'b1, NBIT, -1, 0, 0);
        idle(NBIT);
        check(got_cnt == n0 + 2, "R6 nominal back-to-back", got_cnt - n0, 2);
        check(hist_d[(n0 + 1) % 16] == 8'hC3, "R6 nominal second", hist_d[(n0 + 1) % 16], 8'hC3);

        n0 = got_cnt;
        send(8'h81, 1'b1, NBIT - 1, -1, 0, 0);
        send(8'h7E, 1'b1, NBIT - 1, -1, 0, 0);
        send(8'h24, 1'b1, NBIT - 1, -1, 0, 0);
        idle(2 * NBIT);
        check(got_cnt == n0 + 3, "R6 fast back-to-back count", got_cnt - n0, 3);
        check(hist_d[(n0 + 1) % 16] == 8'h7E, "R6 fast second", hist_d[(n0 + 1) % 16], 8'h7E);
        check(hist_d[(n0 + 2) % 16] == 8'h24, "R6 fast third", hist_d[(n0 + 2) % 16], 8'h24);

        // R5: the data output holds after the last strobe.
        check(rx_data == 8'h24, "R5 data held", rx_data, 8'h24);
        // R1: the receiver stays quiet with the tick running and the line idle.
        check(rx_valid == 1'b0, "R1 quiet", rx_valid, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule